// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small synchronous memory with a two-stage pipeline. Reads and writes can follow each other in any order on consecutive clock edges with no idle cycle between them. Every control input is registered on the rising edge. A read's data is loaded into an output register on the next enabled edge, and the host captures it on the edge after that. A write's data is taken from the bus on the second enabled edge after its address. Because of this, a read and a later write never need the bus in the same slot.

Each word is split into byte lanes. Every lane holds eight data bits and one parity bit, and each lane has its own active-low write enable. Three chip selects have to agree before a cycle counts. A clock-enable input freezes the whole pipeline. An asynchronous sleep input turns the drivers off at once and empties the pipeline, and the array keeps its contents through sleep. A read that follows a write to the same word while that write is still in flight gets the new bytes. This forwarding is done lane by lane.

The bidirectional bus is presented to the pad ring as three signals: `data_i`, `data_o` and a common `data_oe`.

Top module: `tls_sram`

## Requirements
- R1: A cycle is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at an enabled edge. Any other combination is a deselect: it stores nothing and its output slot is not driven.
- R2: A selected cycle with `wr_n`=1 is a read, and its lane enables are ignored. After the next enabled edge, `data_o` holds the addressed word and `data_oe`=1, so the host captures the word on the second enabled edge after the address.
- R3: A selected cycle with `wr_n`=0 is a write. Its word is taken from `data_i` on the second enabled edge after the address. Lane k is bits [9k+8:9k], with bit 9k+8 as that lane's parity bit, and lane k is stored only when `lane_wr_n[k]`=0.
- R4: A write with every bit of `lane_wr_n` high leaves the addressed word unchanged.
- R5: Reads and writes may alternate on consecutive enabled edges with no idle cycle. Each write beat stores only the lanes enabled in its own cycle.
- R6: A read issued while a write to the same address is still in flight returns the new data in the lanes that write enables, and the array data in the other lanes.
- R7: When `clk_en_n`=1 the edge is ignored. Commands on the inputs are dropped, no write is committed, and `data_o` and `data_oe` hold their values.
- R8: `data_oe` is 0 in every output slot that does not belong to a read, including write, deselect and no-operation slots.
- R9: While `sleep`=1, `data_oe` is 0 immediately, without waiting for a clock edge. Sleep empties the pipeline and keeps the array contents. After sleep is released, `data_oe` stays 0 until a new read reaches its slot.
- R10: Holding `rst_n` low at a clock edge empties the pipeline and sets `data_oe` to 0. This includes discarding a read that was already sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Asynchronous low-power request; bus released |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Active-low write enable per byte lane |
| data_i | input | LANES*LANE_W | Bus value seen at the pins (write data) |
| data_o | output | LANES*LANE_W | Read data from the output register |
| data_oe | output | 1 | Drive enable for the bus pads |

## Verification
The bench builds the block with ADDR_W=3, LANES=4 and LANE_W=9. Eight words are few enough that every address is written and read back, and the same locations are then reused by the partial-write, forwarding and ignored-command scenarios. Four lanes that each carry a parity bit allow lane patterns with gaps in the middle, such as 1010 and 0110. Checks against those patterns show that forwarding and partial writes work on each lane separately, and that the parity bit moves with its own lane.

// File: rtl/tls_pkg.sv
// Shared command encoding for the zero-turnaround SRAM.
// Assumes the three chip selects and write enable are sampled together.
package tls_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // Turn raw select and direction pins into a pipeline command.
    function automatic cmd_e decode_cmd(input logic sa_n, input logic sb,
                                        input logic sc_n, input logic wn);
        if (sa_n || !sb || sc_n) begin
            return CMD_NONE;
        end
        return wn ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/tls_cmd_pipe.sv
// Two-stage command pipeline: stage 0 holds the command sampled at the
// last accepted edge, stage 1 the one before it. Address and lane enables
// ride along. Assumes hold freezes everything and sleep empties the
// command slots asynchronously.
module tls_cmd_pipe
    import tls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              hold,
    input  cmd_e              in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_lane_n,
    output cmd_e              s0_cmd,
    output logic [ADDR_W-1:0] s0_addr,
    output cmd_e              s1_cmd,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_lane_n
);

    localparam int DEPTH = 2;

    cmd_e              cmd_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LANES-1:0]  lane_q [DEPTH];

    // Command slots: emptied by sleep or reset, shifted on accepted edges.
    always_ff @(posedge clk or posedge sleep) begin
        if (sleep) begin
            for (int i = 0; i < DEPTH; i++) cmd_q[i] <= CMD_NONE;
        end else if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cmd_q[i] <= CMD_NONE;
        end else if (!hold) begin
            cmd_q[0] <= in_cmd;
            for (int i = 1; i < DEPTH; i++) cmd_q[i] <= cmd_q[i-1];
        end
    end

    // Address and lane enables follow their command down the pipe.
    always_ff @(posedge clk) begin
        if (!hold) begin
            addr_q[0] <= in_addr;
            lane_q[0] <= in_lane_n;
            for (int i = 1; i < DEPTH; i++) begin
                addr_q[i] <= addr_q[i-1];
                lane_q[i] <= lane_q[i-1];
            end
        end
    end

    assign s0_cmd    = cmd_q[0];
    assign s0_addr   = addr_q[0];
    assign s1_cmd    = cmd_q[1];
    assign s1_addr   = addr_q[1];
    assign s1_lane_n = lane_q[1];

endmodule

// File: rtl/tls_lane_array.sv
// Storage split into byte lanes, one small memory per lane, so a write
// touches only enabled lanes. Asynchronous read, synchronous write.
// Assumes contents are not initialised and survive reset and sleep.
module tls_lane_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int WORDS = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];

        // Store this lane only when its enable is active.
        always_ff @(posedge clk) begin
            if (wr_en && !wr_lane_n[k]) begin
                cells[wr_addr] <= wr_data[k*LANE_W +: LANE_W];
            end
        end

        assign rd_data[k*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/tls_read_out.sv
// Read return path: merges bus data from an in-flight write into the
// array word lane by lane, loads the output register, and keeps the drive
// flag. Assumes only stage 1 can hold a write older than the stage 0 read.
module tls_read_out
    import tls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    hold,
    input  cmd_e                    s0_cmd,
    input  logic [ADDR_W-1:0]       s0_addr,
    input  cmd_e                    s1_cmd,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic [LANES-1:0]        s1_lane_n,
    input  logic [LANES*LANE_W-1:0] bus_in,
    input  logic [LANES*LANE_W-1:0] array_q,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    drive_q
);

    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] merged;
    logic              same_word;

    assign same_word = (s1_cmd == CMD_WRITE) && (s1_addr == s0_addr);

    for (genvar k = 0; k < LANES; k++) begin : g_fwd
        logic hit;
        assign hit = same_word && !s1_lane_n[k];
        assign merged[k*LANE_W +: LANE_W] = hit ? bus_in[k*LANE_W +: LANE_W]
                                                : array_q[k*LANE_W +: LANE_W];
    end

    // Output register: captures the merged word for a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!hold && (s0_cmd == CMD_READ)) begin
            q <= merged;
        end
    end

    // Drive flag: set only for the slot that follows a read.
    always_ff @(posedge clk or posedge sleep) begin
        if (sleep) begin
            drive_q <= 1'b0;
        end else if (!rst_n) begin
            drive_q <= 1'b0;
        end else if (!hold) begin
            drive_q <= (s0_cmd == CMD_READ);
        end
    end

endmodule

// File: rtl/tls_sram.sv
// Zero-turnaround pipelined SRAM top. Samples selects, direction, address
// and lane enables on each accepted rising edge. Read data is driven one
// accepted edge later; write data is taken from the bus two accepted edges
// later. Assumes sleep is raised only with the device deselected and the
// pipeline drained of writes.
module tls_sram
    import tls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] data_i,
    output logic [LANES*LANE_W-1:0] data_o,
    output logic                    data_oe
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_e              in_cmd;
    cmd_e              s0_cmd;
    cmd_e              s1_cmd;
    logic [ADDR_W-1:0] s0_addr;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_lane_n;
    logic [DATA_W-1:0] array_q;
    logic              commit;
    logic              drive_q;

    assign in_cmd = decode_cmd(sel_a_n, sel_b, sel_c_n, wr_n);
    assign commit = (s1_cmd == CMD_WRITE) && !clk_en_n;

    tls_cmd_pipe #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .hold      (clk_en_n),
        .in_cmd    (in_cmd),
        .in_addr   (addr),
        .in_lane_n (lane_wr_n),
        .s0_cmd    (s0_cmd),
        .s0_addr   (s0_addr),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .s1_lane_n (s1_lane_n)
    );

    tls_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk       (clk),
        .wr_en     (commit),
        .wr_addr   (s1_addr),
        .wr_lane_n (s1_lane_n),
        .wr_data   (data_i),
        .rd_addr   (s0_addr),
        .rd_data   (array_q)
    );

    tls_read_out #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .hold      (clk_en_n),
        .s0_cmd    (s0_cmd),
        .s0_addr   (s0_addr),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .s1_lane_n (s1_lane_n),
        .bus_in    (data_i),
        .array_q   (array_q),
        .q         (data_o),
        .drive_q   (drive_q)
    );

    assign data_oe = drive_q && !sleep;

endmodule

// File: rtl/tls_sram_checker.sv
// Port-level protocol checks for tls_sram, attached with bind.
// Assumes synchronous active-low reset and sleep raised only when idle.
module tls_sram_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              clk_en_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe
);

    logic picked;
    logic accepted;
    logic rd_go;
    logic wr_go;
    logic idle_go;

    assign picked   = !sel_a_n && sel_b && !sel_c_n;
    assign accepted = rst_n && !clk_en_n && !sleep;
    assign rd_go    = accepted && picked && wr_n;
    assign wr_go    = accepted && picked && !wr_n;
    assign idle_go  = accepted && !picked;

    AST_READ_SLOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && $past(rd_go)) |=> (data_oe || sleep)); // R2

    AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && $past(wr_go)) |=> !data_oe); // R8

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && $past(idle_go)) |=> !data_oe); // R1

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !sleep) |=> $stable(data_o)); // R7

    AST_WAKE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !data_oe); // R9

endmodule

bind tls_sram tls_sram_checker #(.DATA_W(DATA_W)) u_tls_sram_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .clk_en_n (clk_en_n),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .wr_n     (wr_n),
    .data_o   (data_o),
    .data_oe  (data_oe)
);

// File: tb/test_tls_sram.sv
// Directed bench for tls_sram: one task per scenario, each checking itself.
module test_tls_sram;

    localparam int AW = 3;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int WORDS = 1 << AW;
    localparam logic [DW-1:0] FILLER = 36'hF_0F0F_0F0F;
    localparam int K_NONE = 0;
    localparam int K_RD = 1;
    localparam int K_WR = 2;

    logic          clk = 1'b0;
    logic          rst_n, sleep, clk_en_n;
    logic          sel_a_n, sel_b, sel_c_n, wr_n;
    logic [AW-1:0] addr;
    logic [LN-1:0] lane_wr_n;
    logic [DW-1:0] data_i, data_o;
    logic          data_oe;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [WORDS];
    int            h_kind [2];
    logic [AW-1:0] h_addr [2];
    logic [LN-1:0] h_lane [2];
    logic [DW-1:0] h_data [2];
    string         h_tag  [2];

    always #5 clk = ~clk;

    tls_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_tls_sram (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
        .addr(addr), .lane_wr_n(lane_wr_n), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 2; i++) begin
            h_kind[i] = K_NONE;
            h_tag[i]  = "R8";
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return {4'(a ^ s), 32'h5A3C_0000 ^ 32'(s * 40503 + a * 257)};
    endfunction

    // One accepted or stalled cycle: check the slot of the command two
    // accepted edges back, drive its write data, then present a new command.
    task automatic step(input logic sa, input logic sb, input logic sc, input logic wn,
                        input logic [AW-1:0] a, input logic [LN-1:0] ln,
                        input logic [DW-1:0] d, input logic hold, input string tag);
        int kind;
        if (h_kind[1] == K_RD) begin
            chk(h_tag[1], 64'(data_oe), 64'd1);
            chk(h_tag[1], 64'(data_o), 64'(model[h_addr[1]]));
        end else begin
            chk(h_tag[1], 64'(data_oe), 64'd0);
        end
        if (h_kind[1] == K_WR) begin
            data_i = h_data[1];
            if (!hold) begin
                for (int k = 0; k < LN; k++)
                    if (!h_lane[1][k]) model[h_addr[1]][k*LW +: LW] = h_data[1][k*LW +: LW];
            end
        end else begin
            data_i = FILLER;
        end
        sel_a_n = sa; sel_b = sb; sel_c_n = sc; wr_n = wn;
        addr = a; lane_wr_n = ln; clk_en_n = hold;
        kind = (!sa && sb && !sc) ? (wn ? K_RD : K_WR) : K_NONE;
        @(posedge clk);
        if (!hold) begin
            h_kind[1] = h_kind[0]; h_addr[1] = h_addr[0];
            h_lane[1] = h_lane[0]; h_data[1] = h_data[0]; h_tag[1] = h_tag[0];
            h_kind[0] = kind; h_addr[0] = a; h_lane[0] = ln; h_data[0] = d; h_tag[0] = tag;
        end
        @(negedge clk);
    endtask

    task automatic rd(input int a, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), 4'b0000, '0, 1'b0, tag);
    endtask

    task automatic wr(input int a, input logic [LN-1:0] ln, input logic [DW-1:0] d,
                      input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, AW'(a), ln, d, 1'b0, tag);
    endtask

    task automatic nop(input string tag);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0, 4'b1111, '0, 1'b0, tag);
    endtask

    task automatic t_fill();
        for (int a = 0; a < WORDS; a++) wr(a, 4'b0000, pat(a, 1), "R3");
        nop("R8"); nop("R8");
        for (int a = 0; a < WORDS; a++) rd(a, "R2");
        nop("R8"); nop("R8");
    endtask

    task automatic t_partial();
        wr(2, 4'b1010, 36'h1_8765_4321 ^ 36'h8_0200_8020, "R3");
        wr(4, 4'b0111, 36'hF_FFFF_FFFF, "R3");
        nop("R8");
        rd(2, "R3"); rd(4, "R3");
        wr(3, 4'b1111, 36'h0_1234_5678, "R4");
        nop("R8"); nop("R8");
        rd(3, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b1, 3'd5, 4'b1111, '0, 1'b0, "R2");
        nop("R8"); nop("R8");
    endtask

    task automatic t_alternate();
        rd(0, "R5"); wr(5, 4'b0101, pat(5, 7), "R5");
        rd(1, "R5"); wr(6, 4'b1110, pat(6, 9), "R5");
        rd(5, "R5"); wr(0, 4'b0011, pat(0, 3), "R5");
        rd(6, "R5"); rd(0, "R5");
        nop("R8"); nop("R8");
    endtask

    task automatic t_forward();
        wr(2, 4'b0000, pat(2, 11), "R6"); rd(2, "R6");
        wr(3, 4'b1001, pat(3, 12), "R6"); rd(3, "R6");
        wr(4, 4'b0110, pat(4, 13), "R6"); nop("R8"); rd(4, "R6");
        nop("R8"); nop("R8");
    endtask

    task automatic t_deselect();
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 4'b0000, pat(5, 40), 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 4'b0000, pat(5, 41), 1'b0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 3'd5, 4'b0000, pat(5, 42), 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 4'b0000, '0, 1'b0, "R1");
        nop("R8"); nop("R8");
        rd(5, "R1");
        nop("R8"); nop("R8");
    endtask

    task automatic t_stall();
        wr(6, 4'b0000, pat(6, 21), "R7");
        rd(1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 4'b0000, pat(7, 99), 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b1, 3'd7, 4'b0000, '0, 1'b1, "R7");
        nop("R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 4'b0000, pat(7, 98), 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 4'b0000, pat(7, 97), 1'b1, "R7");
        nop("R8"); nop("R8");
        rd(7, "R7"); rd(6, "R7");
        nop("R8"); nop("R8");
    endtask

    task automatic t_sleep();
        rd(3, "R9"); nop("R8");
        chk("R9", 64'(data_oe), 64'd1);
        sleep = 1'b1;
        #1;
        chk("R9", 64'(data_oe), 64'd0);
        clear_hist();
        sel_a_n = 1'b1; clk_en_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", 64'(data_oe), 64'd0);
        end
        sleep = 1'b0;
        #1;
        chk("R9", 64'(data_oe), 64'd0);
        @(negedge clk);
        nop("R9"); nop("R9");
        rd(3, "R9"); rd(2, "R9");
        nop("R8"); nop("R8");
    endtask

    task automatic t_reset_flush();
        rd(4, "R10");
        rst_n = 1'b0;
        sel_a_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", 64'(data_oe), 64'd0);
        clear_hist();
        nop("R10"); nop("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sleep = 1'b0; clk_en_n = 1'b0;
        sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0; wr_n = 1'b1;
        addr = '0; lane_wr_n = '1; data_i = FILLER;
        clear_hist();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", 64'(data_oe), 64'd0);
        t_fill();
        t_partial();
        t_alternate();
        t_forward();
        t_deselect();
        t_stall();
        t_sleep();
        t_reset_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule